// File: doc/BRIEF.md
# Conversion-Complete DMA Request Generator

This block sits beside an analog converter's sequencer. It turns end-of-conversion events into a single DMA request toward a transfer engine. Every channel belongs to one of three channel types, and each type has its own 16-bit enable mask with one bit per channel. When a conversion completes on a channel whose mask bit is set, and the global DMA enable is on, the block raises its request. It also latches the type and channel index of the result that caused the request, so the engine knows which result register to fetch.

The request is withdrawn in one of two ways, chosen by a control bit. In handshake mode, a one-cycle acknowledge from the engine clears it. In read-clear mode, the block watches the result-register read path and clears the request when the specific register that caused it is read. Software writes the masks through a small register port. Each mask is frozen while a conversion run is active, so it has to be set up beforehand.

A conversion that qualifies while a request is still pending does not replace the pending request. It raises an overrun flag. Turning the global enable off drops any pending request.

Top module: `dma_conv_req`

## Requirements
- R1: After reset, all three masks read 0, the control register reads 0 (DMA disabled, handshake mode), `dma_req_o` is low and `overrun_o` is low.
- R2: Register map: address 0, 1 and 2 hold the masks of channel types 0, 1 and 2. Address 3 is control, with bit 0 as the global enable and bit 1 selecting read-clear mode. A completion strobe with a set mask bit and the enable on drives `dma_req_o` high from the next cycle. In the same cycle, `dma_type_o` and `dma_chan_o` carry the completing type and channel.
- R3: A completion on a channel whose bit is clear in its own type's mask raises no request, even if the same channel index is enabled in another type's mask.
- R4: While the enable bit is 0, no completion raises a request.
- R5: Mask writes made while `conv_active_i` is high are ignored, and the mask reads back unchanged. Writes to the control register take effect regardless of `conv_active_i`.
- R6: In handshake mode, `dma_ack_i` high for one cycle while a request is pending clears `dma_req_o` from the next cycle. Result-register reads do not clear the request in this mode.
- R7: In read-clear mode, a read strobe whose address equals {type, channel} of the pending request (type in the upper 2 bits, channel in the lower 4) clears `dma_req_o` from the next cycle. Reads of other addresses and `dma_ack_i` leave the request pending.
- R8: A qualifying completion while a request is pending and not being cleared keeps the latched type and channel and sets `overrun_o` from the next cycle. `overrun_o` clears together with the request.
- R9: If a qualifying completion arrives in the same cycle that the pending request is cleared, the new completion becomes the pending request and `overrun_o` stays low.
- R10: Writing 0 to the enable bit drives `dma_req_o` low from the cycle after the write. The pending request and `overrun_o` are discarded one cycle later, so setting the enable again does not bring the request back.
- R11: A completion strobe with channel type code 3 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| conv_active_i | input | 1 | Conversion run in progress; freezes the masks |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address (0..2 masks, 3 control) |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Combinational readback of the addressed register |
| eoc_valid_i | input | 1 | End-of-conversion strobe |
| eoc_type_i | input | 2 | Channel type of the completed conversion |
| eoc_chan_i | input | 4 | Channel index within its type |
| rd_valid_i | input | 1 | Result-register read strobe |
| rd_addr_i | input | 6 | Read result address {type, channel} |
| dma_ack_i | input | 1 | One-cycle handshake acknowledge |
| dma_req_o | output | 1 | DMA request |
| dma_type_o | output | 2 | Type of the pending request's channel |
| dma_chan_o | output | 4 | Channel of the pending request |
| overrun_o | output | 1 | Qualifying completion arrived while a request was pending |

## Verification
The bench targets the cases where the two clear sources and a new completion can interact.

- **Clear and completion in the same cycle.** A design that gives the clear priority would lose the new channel and drop the request.
- **Completion during a pending request.** A design that lets the newer event win would report the wrong channel and leave the first result unserved.
- **Clear source by mode.** The bench reads a neighbouring result address and asserts acknowledge in the mode that must ignore it. A design that mixes the two sources would clear early.
- **Mask selection.** The bench enables a channel index in one type's mask and completes the same index in another type, which exposes mask bits selected without regard to type.
- **Gated writes and invalid type.** Mask writes during an active run are checked through readback, and the unused type code is sent with an all-ones mask present.

// File: rtl/dma_conv_pkg.sv
package dma_conv_pkg;
  localparam int NUM_TYPES   = 3;
  localparam int CH_PER_TYPE = 16;
  localparam int TYPE_W      = 2;
  localparam int CH_W        = $clog2(CH_PER_TYPE);
  localparam int REG_AW      = $clog2(NUM_TYPES + 1);
  localparam int RD_AW       = TYPE_W + CH_W;
  localparam logic [REG_AW-1:0] CTRL_ADDR = REG_AW'(NUM_TYPES);
endpackage

// File: rtl/dma_mask_regs.sv
module dma_mask_regs
  import dma_conv_pkg::*;
(
  input  logic                                   clk_i,
  input  logic                                   rst_ni,
  input  logic                                   conv_active_i,
  input  logic                                   reg_we_i,
  input  logic [REG_AW-1:0]                      reg_addr_i,
  input  logic [CH_PER_TYPE-1:0]                 reg_wdata_i,
  output logic [CH_PER_TYPE-1:0]                 reg_rdata_o,
  output logic [NUM_TYPES-1:0][CH_PER_TYPE-1:0]  mask_o,
  output logic                                   en_o,
  output logic                                   rd_clr_o
);
  logic [NUM_TYPES-1:0][CH_PER_TYPE-1:0] mask_q;
  logic en_q, rd_clr_q;

  for (genvar t = 0; t < NUM_TYPES; t++) begin : g_mask
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        mask_q[t] <= '0;
      else if (reg_we_i && !conv_active_i && reg_addr_i == REG_AW'(t))
        mask_q[t] <= reg_wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q     <= 1'b0;
      rd_clr_q <= 1'b0;
    end else if (reg_we_i && reg_addr_i == CTRL_ADDR) begin
      en_q     <= reg_wdata_i[0];
      rd_clr_q <= reg_wdata_i[1];
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    for (int t = 0; t < NUM_TYPES; t++)
      if (reg_addr_i == REG_AW'(t)) reg_rdata_o = mask_q[t];
    if (reg_addr_i == CTRL_ADDR) reg_rdata_o[1:0] = {rd_clr_q, en_q};
  end

  assign mask_o   = mask_q;
  assign en_o     = en_q;
  assign rd_clr_o = rd_clr_q;

  AST_MASK_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_active_i |=> $stable(mask_o)); // R5
endmodule

// File: rtl/dma_req_qual.sv
module dma_req_qual
  import dma_conv_pkg::*;
(
  input  logic                                   eoc_valid_i,
  input  logic [TYPE_W-1:0]                      eoc_type_i,
  input  logic [CH_W-1:0]                        eoc_chan_i,
  input  logic [NUM_TYPES-1:0][CH_PER_TYPE-1:0]  mask_i,
  input  logic                                   en_i,
  output logic                                   hit_o
);
  logic [NUM_TYPES-1:0] type_hit;

  // unused type codes match no mask
  for (genvar t = 0; t < NUM_TYPES; t++) begin : g_type
    assign type_hit[t] = (eoc_type_i == TYPE_W'(t)) && mask_i[t][eoc_chan_i];
  end

  assign hit_o = eoc_valid_i && en_i && |type_hit;
endmodule

// File: rtl/dma_req_tracker.sv
module dma_req_tracker
  import dma_conv_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              rd_clr_i,
  input  logic              hit_i,
  input  logic [TYPE_W-1:0] eoc_type_i,
  input  logic [CH_W-1:0]   eoc_chan_i,
  input  logic              ack_i,
  input  logic              rd_valid_i,
  input  logic [RD_AW-1:0]  rd_addr_i,
  output logic              req_o,
  output logic [TYPE_W-1:0] type_o,
  output logic [CH_W-1:0]   chan_o,
  output logic              ovr_o
);
  logic              pend_q, ovr_q;
  logic [TYPE_W-1:0] type_q;
  logic [CH_W-1:0]   chan_q;
  logic              rd_match, clr;

  assign rd_match = rd_valid_i && (rd_addr_i == {type_q, chan_q});
  assign clr      = pend_q && (rd_clr_i ? rd_match : ack_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      ovr_q  <= 1'b0;
      type_q <= '0;
      chan_q <= '0;
    end else if (!en_i) begin
      pend_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else if (hit_i && (!pend_q || clr)) begin
      // a clear in the same cycle frees the slot for the new event
      pend_q <= 1'b1;
      ovr_q  <= 1'b0;
      type_q <= eoc_type_i;
      chan_q <= eoc_chan_i;
    end else if (clr) begin
      pend_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else if (hit_i) begin
      ovr_q  <= 1'b1;
    end
  end

  assign req_o  = pend_q && en_i;
  assign type_o = type_q;
  assign chan_o = chan_q;
  assign ovr_o  = ovr_q;

  AST_RISE_NEEDS_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_o) |-> $past(hit_i)); // R2
  AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !rd_clr_i && ack_i && !hit_i) |=> !req_o); // R6
  AST_READ_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && rd_clr_i && rd_valid_i && rd_addr_i == {type_o, chan_o} && !hit_i) |=> !req_o); // R7
  AST_OVERRUN_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && hit_i && !ack_i && !rd_valid_i) |=> (req_o && ovr_o && $stable(chan_o) && $stable(type_o))); // R8
  AST_DISABLE_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!pend_q && !ovr_q)); // R10
endmodule

// File: rtl/dma_conv_req.sv
module dma_conv_req
  import dma_conv_pkg::*;
(
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   conv_active_i,
  input  logic                   reg_we_i,
  input  logic [REG_AW-1:0]      reg_addr_i,
  input  logic [CH_PER_TYPE-1:0] reg_wdata_i,
  output logic [CH_PER_TYPE-1:0] reg_rdata_o,
  input  logic                   eoc_valid_i,
  input  logic [TYPE_W-1:0]      eoc_type_i,
  input  logic [CH_W-1:0]        eoc_chan_i,
  input  logic                   rd_valid_i,
  input  logic [RD_AW-1:0]       rd_addr_i,
  input  logic                   dma_ack_i,
  output logic                   dma_req_o,
  output logic [TYPE_W-1:0]      dma_type_o,
  output logic [CH_W-1:0]        dma_chan_o,
  output logic                   overrun_o
);
  logic [NUM_TYPES-1:0][CH_PER_TYPE-1:0] mask;
  logic en, rd_clr, hit;

  dma_mask_regs u_regs (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .conv_active_i (conv_active_i),
    .reg_we_i      (reg_we_i),
    .reg_addr_i    (reg_addr_i),
    .reg_wdata_i   (reg_wdata_i),
    .reg_rdata_o   (reg_rdata_o),
    .mask_o        (mask),
    .en_o          (en),
    .rd_clr_o      (rd_clr)
  );

  dma_req_qual u_qual (
    .eoc_valid_i (eoc_valid_i),
    .eoc_type_i  (eoc_type_i),
    .eoc_chan_i  (eoc_chan_i),
    .mask_i      (mask),
    .en_i        (en),
    .hit_o       (hit)
  );

  dma_req_tracker u_trk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en),
    .rd_clr_i   (rd_clr),
    .hit_i      (hit),
    .eoc_type_i (eoc_type_i),
    .eoc_chan_i (eoc_chan_i),
    .ack_i      (dma_ack_i),
    .rd_valid_i (rd_valid_i),
    .rd_addr_i  (rd_addr_i),
    .req_o      (dma_req_o),
    .type_o     (dma_type_o),
    .chan_o     (dma_chan_o),
    .ovr_o      (overrun_o)
  );

  AST_NO_REQ_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en && !$past(en)) |-> !dma_req_o); // R4
endmodule

// File: tb/dma_conv_req_bench.sv
module dma_conv_req_bench;
  import dma_conv_pkg::*;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic conv_active = 1'b0, reg_we = 1'b0, eoc_valid = 1'b0, rd_valid = 1'b0, dma_ack = 1'b0;
  logic [REG_AW-1:0] reg_addr = '0;
  logic [CH_PER_TYPE-1:0] reg_wdata = '0, reg_rdata;
  logic [TYPE_W-1:0] eoc_type = '0, dma_type;
  logic [CH_W-1:0] eoc_chan = '0, dma_chan;
  logic [RD_AW-1:0] rd_addr = '0;
  logic dma_req, overrun;

  always #2 clk = ~clk;

  dma_conv_req u_dma_conv_req (
    .clk_i(clk), .rst_ni(rst_ni), .conv_active_i(conv_active),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .eoc_valid_i(eoc_valid), .eoc_type_i(eoc_type), .eoc_chan_i(eoc_chan),
    .rd_valid_i(rd_valid), .rd_addr_i(rd_addr), .dma_ack_i(dma_ack),
    .dma_req_o(dma_req), .dma_type_o(dma_type), .dma_chan_o(dma_chan), .overrun_o(overrun)
  );

  typedef struct {
    int at;
    bit is_reg;
    logic req;
    logic [TYPE_W-1:0] typ;
    logic [CH_W-1:0] ch;
    logic ovr;
    logic [CH_PER_TYPE-1:0] rdata;
    string tag;
  } item_t;

  item_t q[$];
  int cyc = 0, n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compare queued expectations at the negedge of their cycle
  initial forever begin
    @(negedge clk);
    while (q.size() > 0 && q[0].at <= cyc) begin
      item_t it;
      it = q.pop_front();
      n_tests++;
      if (it.at < cyc) begin
        n_fail++;
        $display("FAIL %s: check missed its cycle (at=%0d now=%0d)", it.tag, it.at, cyc);
      end else if (it.is_reg) begin
        if (reg_rdata !== it.rdata) begin
          n_fail++;
          $display("FAIL %s: rdata=%h expected %h", it.tag, reg_rdata, it.rdata);
        end
      end else if (dma_req !== it.req || overrun !== it.ovr ||
                   (it.req && (dma_type !== it.typ || dma_chan !== it.ch))) begin
        n_fail++;
        $display("FAIL %s: req=%b type=%0d chan=%0d ovr=%b expected req=%b type=%0d chan=%0d ovr=%b",
                 it.tag, dma_req, dma_type, dma_chan, overrun, it.req, it.typ, it.ch, it.ovr);
      end
    end
  end

  task automatic cyc_begin();
    @(posedge clk); #1;
    reg_we = 1'b0; eoc_valid = 1'b0; rd_valid = 1'b0; dma_ack = 1'b0;
  endtask

  task automatic exp_out(int off, logic req, int t, int c, logic ovr, string tag);
    item_t it;
    it.at = cyc + off; it.is_reg = 1'b0; it.req = req;
    it.typ = TYPE_W'(t); it.ch = CH_W'(c); it.ovr = ovr; it.rdata = '0; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic chk_reg(int a, logic [CH_PER_TYPE-1:0] d, string tag);
    item_t it;
    cyc_begin();
    reg_addr = REG_AW'(a);
    it.at = cyc; it.is_reg = 1'b1; it.req = 1'b0; it.typ = '0; it.ch = '0;
    it.ovr = 1'b0; it.rdata = d; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic wr(int a, logic [CH_PER_TYPE-1:0] d);
    cyc_begin(); reg_we = 1'b1; reg_addr = REG_AW'(a); reg_wdata = d;
  endtask

  task automatic eoc(int t, int c);
    cyc_begin(); eoc_valid = 1'b1; eoc_type = TYPE_W'(t); eoc_chan = CH_W'(c);
  endtask

  task automatic ack();
    cyc_begin(); dma_ack = 1'b1;
  endtask

  task automatic rd(int t, int c);
    cyc_begin(); rd_valid = 1'b1; rd_addr = {TYPE_W'(t), CH_W'(c)};
  endtask

  task automatic ack_eoc(int t, int c);
    cyc_begin(); dma_ack = 1'b1; eoc_valid = 1'b1; eoc_type = TYPE_W'(t); eoc_chan = CH_W'(c);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    // R1 reset state
    chk_reg(0, 16'h0000, "R1 mask0");
    chk_reg(1, 16'h0000, "R1 mask1");
    chk_reg(2, 16'h0000, "R1 mask2");
    chk_reg(3, 16'h0000, "R1 ctrl");
    exp_out(0, 0, 0, 0, 0, "R1 outputs");
    // R4 disabled
    wr(0, 16'h0001);
    eoc(0, 0);            exp_out(1, 0, 0, 0, 0, "R4 no req while disabled");
    // R2 basic request, handshake mode
    wr(3, 16'h0001);
    eoc(0, 0);            exp_out(1, 1, 0, 0, 0, "R2 req type0 chan0");
    // R6 read ignored, ack clears
    rd(0, 0);             exp_out(1, 1, 0, 0, 0, "R6 read ignored in handshake mode");
    ack();                exp_out(1, 0, 0, 0, 0, "R6 ack clears");
    // R3 mask per type
    eoc(1, 0);            exp_out(1, 0, 0, 0, 0, "R3 same index other type");
    eoc(0, 1);            exp_out(1, 0, 0, 0, 0, "R3 unmasked channel");
    // R5 frozen masks
    conv_active = 1'b1;
    wr(1, 16'h8000);
    wr(3, 16'h0001);
    chk_reg(1, 16'h0000, "R5 mask write ignored while active");
    chk_reg(3, 16'h0001, "R5 ctrl write accepted while active");
    conv_active = 1'b0;
    wr(1, 16'h8000);
    chk_reg(1, 16'h8000, "R5 mask write when idle");
    eoc(1, 15);           exp_out(1, 1, 1, 15, 0, "R2 req type1 chan15");
    // R8 overrun
    eoc(0, 0);            exp_out(1, 1, 1, 15, 1, "R8 overrun keeps first channel");
    ack();                exp_out(1, 0, 0, 0, 0, "R8 overrun clears with request");
    // R9 clear and new event same cycle
    eoc(0, 0);            exp_out(1, 1, 0, 0, 0, "R9 setup");
    ack_eoc(1, 15);       exp_out(1, 1, 1, 15, 0, "R9 new event replaces cleared one");
    ack();                exp_out(1, 0, 0, 0, 0, "R9 cleared");
    // R11 invalid type
    wr(2, 16'hFFFF);
    eoc(3, 5);            exp_out(1, 0, 0, 0, 0, "R11 type code 3 ignored");
    eoc(2, 5);            exp_out(1, 1, 2, 5, 0, "R2 req type2 chan5");
    // R7 read-clear mode
    wr(3, 16'h0003);
    ack();                exp_out(1, 1, 2, 5, 0, "R7 ack ignored in read-clear mode");
    rd(2, 4);             exp_out(1, 1, 2, 5, 0, "R7 other address ignored");
    rd(1, 5);             exp_out(1, 1, 2, 5, 0, "R7 other type ignored");
    rd(2, 5);             exp_out(1, 0, 0, 0, 0, "R7 matching read clears");
    // R10 disable drops
    eoc(0, 0);            exp_out(1, 1, 0, 0, 0, "R10 setup");
    eoc(0, 0);            exp_out(1, 1, 0, 0, 1, "R10 setup overrun");
    wr(3, 16'h0000);      exp_out(1, 0, 0, 0, 1, "R10 request drops after disable");
                          exp_out(2, 0, 0, 0, 0, "R10 overrun discarded");
    cyc_begin();
    wr(3, 16'h0001);      exp_out(1, 0, 0, 0, 0, "R10 request not restored");
    chk_reg(3, 16'h0001, "R2 ctrl readback");
    repeat (4) cyc_begin();
    if (q.size() != 0) begin
      n_tests++; n_fail++;
      $display("FAIL scoreboard: %0d expectations left unchecked, expected 0", q.size());
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule